// File: doc/BRIEF.md
# Power-Down Termination Mode Tracker

This block sits on the controller side of a DDR3 memory interface. It counts clock cycles to work out how the DRAM currently treats its termination-enable pin around precharge power-down with the DLL off. Four modes are possible. In synchronous mode the DRAM applies termination a fixed number of clocks after the pin changes. In asynchronous mode termination follows the pin after an analog delay. Two transition modes lie between these, and during them either behaviour may apply. The block reads the CKE level, a strobe that marks each issued refresh, and the requested termination level. It returns the mode, the pin level to drive, and a flag that is high only while termination is known to have reached the driven level.

Entry into power-down opens an entry window. Its length is the larger of the anticipation time (write latency minus one) and whatever part of the refresh cycle time is still running when CKE falls. Exit from power-down opens an exit window of the anticipation time plus the DLL-off exit time. Inside either window the pin drive is scheduled conservatively: the pin changes only after the previous change has settled under the worst-case bound. Asynchronous delays are treated as whole-cycle worst-case bounds derived from the clock period.

Top module: `odt_pd_tracker`

## Requirements
- R1: While reset is asserted, `mode` is 0 (synchronous), `odtPin` is 0 and `termSettled` is 1.
- R2: Mode encoding is 0 synchronous, 1 entry transition, 2 asynchronous, 3 exit transition. When CKE is sampled low after being high in mode 0, the mode becomes 1 on the next cycle. It holds for W cycles, where W = max(cfgWl-1, remaining refresh count), and then becomes 2.
- R3: A refresh strobe loads the remaining refresh count with cfgTrfc. The count then drops by one per cycle until it reaches zero. If the strobe comes in the same cycle as the CKE fall, the full cfgTrfc is used for W.
- R4: When CKE is sampled high after being low in mode 1 or 2, the mode becomes 3 on the next cycle. It holds for cfgWl-1+cfgTxpdll cycles and then becomes 0.
- R5: A CKE fall in mode 3 and a CKE rise in mode 0 have no effect on the mode.
- R6: In modes 0 and 2, `odtPin` takes the value of `odtReq` one cycle later.
- R7: In modes 1 and 3, `odtPin` holds its value while `termSettled` is low, and takes `odtReq` once it is high.
- R8: After each change of `odtPin`, `termSettled` is low for D cycles. D is set by the mode in the cycle of the change: cfgWl-1 in mode 0, ceil(8.5 ns / clock period) in mode 2, and the larger of the two in modes 1 and 3. Otherwise `termSettled` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckeIn | input | 1 | CKE level as driven to the DRAM |
| refStrobe | input | 1 | One-cycle pulse for each refresh issued |
| odtReq | input | 1 | Requested termination level |
| cfgWl | input | WL_W | Write latency in cycles (5 or more) |
| cfgTrfc | input | CNT_W | Refresh cycle time in cycles |
| cfgTxpdll | input | CNT_W | DLL-off power-down exit time in cycles |
| mode | output | 2 | Current termination timing mode |
| odtPin | output | 1 | Termination pin level to drive |
| termSettled | output | 1 | Termination has reached the pin level |

## Verification
Two collisions matter most. The first is a refresh strobe in the same cycle as the CKE fall, where the entry window must use the freshly loaded refresh time and not the stale remainder. The second is a pin request that changes while a transition window is still unsettled, where the hold must win over the request. Both are driven directly. The first is judged by counting the cycles spent in mode 1. The second is judged by reading the pin two cycles after a conflicting request. A behavioural reference model is compared against all three outputs on every clock, including a long stretch of random CKE toggles, refreshes and pin requests.

// File: rtl/odt_pd_pkg.sv
package odt_pd_pkg;

  typedef enum logic [1:0] {
    MD_SYNC  = 2'd0,
    MD_ENTRY = 2'd1,
    MD_ASYNC = 2'd2,
    MD_EXIT  = 2'd3
  } odt_mode_e;

  // control -> datapath window strobes
  typedef struct packed {
    logic loadEntry;
    logic loadExit;
    logic stepWin;
  } win_strb_t;

  // datapath -> control status
  typedef struct packed {
    logic ckeFall;
    logic ckeRise;
    logic winLast;
  } win_stat_t;

endpackage

// File: rtl/odt_pd_ctrl.sv
module odt_pd_ctrl
  import odt_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  win_stat_t stat,
  output win_strb_t strb,
  output odt_mode_e mode
);

  odt_mode_e modeNext;

  always_comb begin
    modeNext = mode;
    strb     = '0;
    unique case (mode)
      MD_SYNC: begin
        if (stat.ckeFall) begin
          modeNext       = MD_ENTRY;
          strb.loadEntry = 1'b1;
        end
      end
      MD_ENTRY: begin
        if (stat.ckeRise) begin
          modeNext      = MD_EXIT;
          strb.loadExit = 1'b1;
        end else if (stat.winLast) begin
          modeNext = MD_ASYNC;
        end else begin
          strb.stepWin = 1'b1;
        end
      end
      MD_ASYNC: begin
        if (stat.ckeRise) begin
          modeNext      = MD_EXIT;
          strb.loadExit = 1'b1;
        end
      end
      MD_EXIT: begin
        if (stat.winLast) modeNext = MD_SYNC;
        else              strb.stepWin = 1'b1;
      end
      default: modeNext = MD_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MD_SYNC;
    else       mode <= modeNext;
  end

  // R2: a CKE fall in synchronous mode opens the entry window
  p_entry_from_sync_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_SYNC && stat.ckeFall) |=> mode == MD_ENTRY);

  // R2: synchronous mode never jumps straight to asynchronous or exit
  p_sync_no_skip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_SYNC) |=> (mode == MD_SYNC || mode == MD_ENTRY));

  // R4: a CKE rise while powered down opens the exit window
  p_exit_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MD_ENTRY || mode == MD_ASYNC) && stat.ckeRise) |=> mode == MD_EXIT);

  // R5: a CKE rise in synchronous mode is ignored
  p_sync_ignores_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_SYNC && stat.ckeRise) |=> mode == MD_SYNC);

  // R5: a CKE fall during the exit window does not restart entry
  p_exit_ignores_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_EXIT && !stat.winLast) |=> mode == MD_EXIT);

endmodule

// File: rtl/odt_pd_dp.sv
module odt_pd_dp
  import odt_pd_pkg::*;
#(
  parameter int WL_W         = 5,
  parameter int CNT_W        = 10,
  parameter int SET_W        = 6,
  parameter int CLK_PS       = 8000,
  parameter int ASYNC_MAX_PS = 8500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ckeIn,
  input  logic             refStrobe,
  input  logic             odtReq,
  input  logic [WL_W-1:0]  cfgWl,
  input  logic [CNT_W-1:0] cfgTrfc,
  input  logic [CNT_W-1:0] cfgTxpdll,
  input  odt_mode_e        mode,
  input  win_strb_t        strb,
  output win_stat_t        stat,
  output logic             odtPin,
  output logic             termSettled
);

  localparam int WIN_W         = CNT_W + 1;
  localparam int ASYNC_MAX_CYC = (ASYNC_MAX_PS + CLK_PS - 1) / CLK_PS;
  localparam logic [SET_W-1:0] ASYNC_DLY = SET_W'(ASYNC_MAX_CYC);

  logic             ckePrev;
  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] refNow;
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W-1:0] anticip;
  logic [WIN_W-1:0] entryWin;
  logic [WIN_W-1:0] exitWin;
  logic [SET_W-1:0] settleCnt;
  logic [SET_W-1:0] syncDly;
  logic [SET_W-1:0] transDly;
  logic [SET_W-1:0] chgDly;
  logic             inTrans;
  logic             pinNext;

  // ---------------- CKE edge detection ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ckePrev <= 1'b1;
    else       ckePrev <= ckeIn;
  end

  assign stat.ckeFall = ckePrev & ~ckeIn;
  assign stat.ckeRise = ~ckePrev & ckeIn;
  assign stat.winLast = (winCnt == WIN_W'(1));

  // ---------------- remaining refresh time ----------------
  assign refNow = refStrobe ? cfgTrfc : refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refCnt <= '0;
    else if (refStrobe)     refCnt <= cfgTrfc;
    else if (refCnt != '0)  refCnt <= refCnt - CNT_W'(1);
  end

  // ---------------- entry / exit window ----------------
  assign anticip  = WIN_W'(cfgWl) - WIN_W'(1);
  assign entryWin = (WIN_W'(refNow) > anticip) ? WIN_W'(refNow) : anticip;
  assign exitWin  = anticip + WIN_W'(cfgTxpdll);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              winCnt <= '0;
    else if (strb.loadEntry) winCnt <= entryWin;
    else if (strb.loadExit)  winCnt <= exitWin;
    else if (strb.stepWin)   winCnt <= winCnt - WIN_W'(1);
  end

  // ---------------- worst-case settle delay per mode ----------------
  assign syncDly = SET_W'(cfgWl) - SET_W'(1);

  generate
    if (ASYNC_MAX_CYC == 0) begin : g_noAsyncFloor
      assign transDly = syncDly;
    end else begin : g_asyncFloor
      assign transDly = (syncDly > ASYNC_DLY) ? syncDly : ASYNC_DLY;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MD_SYNC:  chgDly = syncDly;
      MD_ASYNC: chgDly = ASYNC_DLY;
      default:  chgDly = transDly;
    endcase
  end

  // ---------------- pin scheduling ----------------
  assign inTrans     = (mode == MD_ENTRY) || (mode == MD_EXIT);
  assign termSettled = (settleCnt == '0);
  assign pinNext     = (inTrans && !termSettled) ? odtPin : odtReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odtPin    <= 1'b0;
      settleCnt <= '0;
    end else begin
      odtPin <= pinNext;
      if (pinNext != odtPin)      settleCnt <= chgDly;
      else if (settleCnt != '0)   settleCnt <= settleCnt - SET_W'(1);
    end
  end

  // R3: remaining refresh time counts down by one when not reloaded
  p_ref_countdown_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!refStrobe && refCnt != '0) |=> refCnt == $past(refCnt) - CNT_W'(1));

  // R3: a refresh strobe reloads the full refresh time
  p_ref_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    refStrobe |=> refCnt == $past(cfgTrfc));

  // R2: a transition window is never empty while its mode is active
  p_win_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_ENTRY || mode == MD_EXIT) |-> winCnt != '0);

  // R7: unsettled transition holds the pin
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MD_ENTRY || mode == MD_EXIT) && settleCnt != '0) |=> $stable(odtPin));

  // R8: a pin change is always followed by an unsettled interval
  p_settle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (odtPin != $past(odtPin)) |-> !termSettled);

endmodule

// File: rtl/odt_pd_tracker.sv
module odt_pd_tracker
  import odt_pd_pkg::*;
#(
  parameter int WL_W         = 5,
  parameter int CNT_W        = 10,
  parameter int SET_W        = 6,
  parameter int CLK_PS       = 8000,
  parameter int ASYNC_MAX_PS = 8500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ckeIn,
  input  logic             refStrobe,
  input  logic             odtReq,
  input  logic [WL_W-1:0]  cfgWl,
  input  logic [CNT_W-1:0] cfgTrfc,
  input  logic [CNT_W-1:0] cfgTxpdll,
  output logic [1:0]       mode,
  output logic             odtPin,
  output logic             termSettled
);

  win_strb_t strb;
  win_stat_t stat;
  odt_mode_e curMode;

  odt_pd_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb),
    .mode (curMode)
  );

  odt_pd_dp #(
    .WL_W         (WL_W),
    .CNT_W        (CNT_W),
    .SET_W        (SET_W),
    .CLK_PS       (CLK_PS),
    .ASYNC_MAX_PS (ASYNC_MAX_PS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ckeIn       (ckeIn),
    .refStrobe   (refStrobe),
    .odtReq      (odtReq),
    .cfgWl       (cfgWl),
    .cfgTrfc     (cfgTrfc),
    .cfgTxpdll   (cfgTxpdll),
    .mode        (curMode),
    .strb        (strb),
    .stat        (stat),
    .odtPin      (odtPin),
    .termSettled (termSettled)
  );

  assign mode = curMode;

endmodule

// File: tb/odt_pd_tracker_test.sv
module odt_pd_tracker_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ckeIn = 1'b1;
  logic       refStrobe = 1'b0;
  logic       odtReq = 1'b0;
  logic [4:0] cfgWl = 5'd6;
  logic [9:0] cfgTrfc = 10'd12;
  logic [9:0] cfgTxpdll = 10'd4;
  logic [1:0] mode;
  logic       odtPin;
  logic       termSettled;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;

  odt_pd_tracker uut (
    .clk(clk), .rstN(rstN), .ckeIn(ckeIn), .refStrobe(refStrobe), .odtReq(odtReq),
    .cfgWl(cfgWl), .cfgTrfc(cfgTrfc), .cfgTxpdll(cfgTxpdll),
    .mode(mode), .odtPin(odtPin), .termSettled(termSettled)
  );

  always #4 clk = ~clk;  // 125 MHz

  // ---------------- behavioural reference model ----------------
  localparam int ASYNC_CYC = (8500 + 8000 - 1) / 8000;
  int mMode = 0, mWin = 0, mRef = 0, mPin = 0, mSet = 0, mCkeP = 1;
  int refNow, anticip, dly, pinN;
  bit fall, rise, trans;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mWin = 0; mRef = 0; mPin = 0; mSet = 0; mCkeP = 1;
    end else begin
      started = 1;
      anticip = int'(cfgWl) - 1;
      refNow  = refStrobe ? int'(cfgTrfc) : mRef;
      fall = (mCkeP == 1) && !ckeIn;
      rise = (mCkeP == 0) && ckeIn;
      trans = (mMode == 1) || (mMode == 3);
      pinN = (trans && mSet != 0) ? mPin : int'(odtReq);
      case (mMode)
        0: dly = anticip;
        2: dly = ASYNC_CYC;
        default: dly = (anticip > ASYNC_CYC) ? anticip : ASYNC_CYC;
      endcase
      if (pinN != mPin) mSet = dly;
      else if (mSet > 0) mSet = mSet - 1;
      mPin = pinN;
      case (mMode)
        0: if (fall) begin mMode = 1; mWin = (refNow > anticip) ? refNow : anticip; end
        1: if (rise) begin mMode = 3; mWin = anticip + int'(cfgTxpdll); end
           else if (mWin == 1) mMode = 2;
           else mWin = mWin - 1;
        2: if (rise) begin mMode = 3; mWin = anticip + int'(cfgTxpdll); end
        default: if (mWin == 1) mMode = 0; else mWin = mWin - 1;
      endcase
      if (refStrobe) mRef = int'(cfgTrfc);
      else if (mRef > 0) mRef = mRef - 1;
      mCkeP = int'(ckeIn);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison: mode (R2), pin (R6), settle flag (R8)
  always @(negedge clk) begin
    if (started && rstN && !done) begin
      chk(int'(mode) == mMode, "R2 mode", int'(mode), mMode);
      chk(int'(odtPin) == mPin, "R6 pin", int'(odtPin), mPin);
      chk(termSettled == (mSet == 0), "R8 settled", int'(termSettled), int'(mSet == 0));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic settleRun(output int n, output bit pinSeen);
    n = 0;
    @(negedge clk);
    pinSeen = odtPin;
    while (!termSettled && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic lenRun(input int want, output int n);
    n = 0;
    @(negedge clk);
    refStrobe = 1'b0;
    while (int'(mode) == want && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  int n;
  bit p;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R1 mode", int'(mode), 0);
    chk(odtPin == 1'b0, "R1 pin", int'(odtPin), 0);
    chk(termSettled == 1'b1, "R1 settled", int'(termSettled), 1);
    rstN = 1'b1;
    @(negedge clk);

    // synchronous mode pin changes
    odtReq = 1'b1;
    settleRun(n, p);
    chk(p == 1'b1, "R6 sync pin", int'(p), 1);
    chk(n == 5, "R8 sync delay", n, 5);
    odtReq = 1'b0;
    settleRun(n, p);
    chk(n == 5, "R8 sync delay", n, 5);

    // entry without refresh
    ckeIn = 1'b0;
    lenRun(1, n);
    chk(n == 5, "R2 entry length", n, 5);
    chk(mode == 2'd2, "R2 async reached", int'(mode), 2);

    // asynchronous pin change
    odtReq = 1'b1;
    settleRun(n, p);
    chk(p == 1'b1, "R6 async pin", int'(p), 1);
    chk(n == ASYNC_CYC, "R8 async delay", n, ASYNC_CYC);

    // exit
    ckeIn = 1'b1;
    lenRun(3, n);
    chk(n == 9, "R4 exit length", n, 9);
    chk(mode == 2'd0, "R4 back to sync", int'(mode), 0);
    repeat (3) @(negedge clk);

    // hold during entry window
    ckeIn = 1'b0;
    @(negedge clk);
    odtReq = 1'b0;
    @(negedge clk);
    odtReq = 1'b1;
    @(negedge clk);
    chk(odtPin == 1'b0, "R7 held", int'(odtPin), 0);
    @(negedge clk);
    chk(odtPin == 1'b0, "R7 held", int'(odtPin), 0);
    repeat (8) @(negedge clk);
    chk(mode == 2'd2, "R7 async", int'(mode), 2);
    chk(odtPin == 1'b1, "R7 released", int'(odtPin), 1);

    // ignored edges
    ckeIn = 1'b1;
    @(negedge clk);
    ckeIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(mode == 2'd3, "R5 fall in exit", int'(mode), 3);
    repeat (12) @(negedge clk);
    chk(mode == 2'd0, "R5 no entry", int'(mode), 0);
    ckeIn = 1'b1;
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R5 rise in sync", int'(mode), 0);

    // refresh two cycles before fall
    refStrobe = 1'b1;
    @(negedge clk);
    refStrobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ckeIn = 1'b0;
    lenRun(1, n);
    chk(n == 10, "R3 remaining refresh", n, 10);
    ckeIn = 1'b1;
    lenRun(3, n);

    // refresh in the same cycle as the fall
    refStrobe = 1'b1;
    ckeIn = 1'b0;
    lenRun(1, n);
    chk(n == 12, "R3 same cycle", n, 12);
    ckeIn = 1'b1;
    lenRun(3, n);

    // refresh long expired
    refStrobe = 1'b1;
    @(negedge clk);
    refStrobe = 1'b0;
    repeat (14) @(negedge clk);
    ckeIn = 1'b0;
    lenRun(1, n);
    chk(n == 5, "R3 expired refresh", n, 5);
    ckeIn = 1'b1;
    lenRun(3, n);

    // random stretch with a second configuration
    cfgWl = 5'd5;
    cfgTrfc = 10'd9;
    cfgTxpdll = 10'd0;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      odtReq = lfsr[0];
      refStrobe = (lfsr[3:1] == 3'd0);
      if (lfsr[7:4] == 4'd0) ckeIn = ~ckeIn;
      @(negedge clk);
    end
    refStrobe = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule